// File: doc/BRIEF.md
# Soft-Decision Rate-1/2 K=7 Viterbi Decoder

This block recovers user data from a rate 1/2, constraint length 7 convolutionally encoded frame. The channel symbols are 8-bit soft values and arrive one pair per transfer on a valid/ready stream. A frame opens with a one-cycle `frame_start` pulse. The pulse supplies the user bit count, the encoder state at the start of the frame, the encoder state reached after the tail, and the symbol polarity and ordering options.

For every pair the decoder runs one trellis step. A step works through the 64 states as 32 butterflies, one per clock. It then renormalises the path metrics and stores one survivor decision bit per state. After the last tail pair, the decoder traces back from the supplied terminal state and streams the decoded user bits out as bytes, first bit in the most significant position.

Symbol phasing, puncturing and other code rates are handled elsewhere.

Top module: `sdv_decoder`

## Requirements
- R1: A symbol pair is taken on each clock edge where `sym_valid` and `sym_ready` are both high, and `sym_ready` is high only while the decoder waits for a pair. A symbol of 0 is a confident 0 and a symbol of 255 is a confident 1. A symbol's branch cost is its distance to the expected value (0 or 255), so erased symbols (128) and sparse fully flipped symbols still decode correctly.
- R2: The encoder state holds the last six input bits, newest in bit 0, and the next state is {state[4:0], bit}. Output A is the parity of {state, bit} ANDed with octal 171, and output B uses octal 133. Error-free symbols decode to the original bits.
- R3: `start_state` is sampled at an accepted `frame_start`. That state's metric starts at 0 and every other state starts at 4096.
- R4: Six tail bits follow the user bits, and they drive the encoder into `end_state`. Traceback starts at `end_state`, and tail bits never appear in the output.
- R5: Path metrics are 16 bits wide. After each step the smallest metric is subtracted from all 64, so bit 15 of a stored metric is never set.
- R6: `inv_a` and `inv_b` complement the expected value of output A and output B respectively. Both are sampled at an accepted `frame_start`.
- R7: With `swap_pair` at 0, `sym_first` carries output A and `sym_second` carries output B. With `swap_pair` at 1 the two are exchanged. The flag is sampled at an accepted `frame_start`.
- R8: The decoder emits ceil(n/8) bytes for n user bits, one per cycle with `byte_valid` high. Frame bit i is placed in byte i/8 at bit position 7-(i mod 8). Unused low bits of the final byte are 0, and `byte_last` marks only the final byte.
- R9: A `frame_start` with `frame_bits` equal to 0 or above MAX_BITS (64) sets `len_err`. The decoder then stays idle and ignores symbols. The next accepted `frame_start` clears `len_err`.
- R10: After a pair is accepted, `sym_ready` rises again exactly 33 cycles later (32 butterfly cycles plus one commit cycle). The exception is the frame's last pair.
- R11: `busy` goes high at an accepted `frame_start` and falls on the cycle after `byte_last`. While `busy` is high, `frame_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a frame; sampled only while idle |
| frame_bits | input | 7 | User bit count, tail excluded |
| start_state | input | 6 | Encoder state at frame start |
| end_state | input | 6 | Encoder state after the tail |
| inv_a | input | 1 | Complement expected output A |
| inv_b | input | 1 | Complement expected output B |
| swap_pair | input | 1 | First symbol of a pair belongs to output B |
| sym_valid | input | 1 | Symbol pair offered |
| sym_ready | output | 1 | Decoder waiting for a pair |
| sym_first | input | 8 | First soft symbol of the pair |
| sym_second | input | 8 | Second soft symbol of the pair |
| byte_valid | output | 1 | Decoded byte present |
| byte_data | output | 8 | Decoded byte, earliest bit in bit 7 |
| byte_last | output | 1 | Final byte of the frame |
| busy | output | 1 | Frame in progress |
| len_err | output | 1 | Last frame request had an illegal length |

## Verification
The embedded assertions check the following on every cycle:
- metric headroom;
- that `sym_ready` and `byte_valid` are never high together;
- that `sym_ready` drops after each accepted pair;
- the rejection of illegal lengths;
- that decision writes stay inside the decision store;
- that `byte_last` only accompanies a valid byte;
- that `busy` falls right after the final byte.

Only the bench scenarios can show that the bytes actually match the encoded data. They do this with a bench-side encoder, which also covers symbol polarity, pair order, non-zero start and end states, partial final bytes and noisy or erased symbols. The 33-cycle step time and the recovery after a rejected length are likewise shown only by those scenarios.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
    localparam int CONSTR = 7;
    localparam int STW    = CONSTR - 1;
    localparam int NSTATE = 1 << STW;
    localparam int NPAIR  = NSTATE / 2;
    localparam int SYMW   = 8;
    localparam int BMW    = SYMW + 1;
    localparam int MW     = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_ACS, ST_COMMIT, ST_TRACE, ST_EMIT
    } phase_t;

    typedef struct packed {
        logic inv_a;
        logic inv_b;
        logic swap;
    } cfg_t;

    // Parity of the encoder window masked by a generator.
    function automatic logic gen_parity(input logic [CONSTR-1:0] poly,
                                        input logic [CONSTR-1:0] win);
        return ^(poly & win);
    endfunction

    // Distance of a soft symbol from the ideal 0 or 255.
    function automatic logic [BMW-1:0] sym_cost(input logic [SYMW-1:0] r,
                                                input logic expect_one);
        return expect_one ? {1'b0, ~r} : {1'b0, r};
    endfunction
endpackage

// File: rtl/sdv_bmu.sv
module sdv_bmu
    import sdv_pkg::*;
#(
    parameter logic [CONSTR-1:0] POLY_A = 7'o171,
    parameter logic [CONSTR-1:0] POLY_B = 7'o133
) (
    input  logic [STW-2:0]         pair_idx,
    input  cfg_t                   cfg,
    input  logic [SYMW-1:0]        sym_first,
    input  logic [SYMW-1:0]        sym_second,
    output logic [3:0][BMW-1:0]    bm
);
    logic [SYMW-1:0] ra, rb;
    assign ra = cfg.swap ? sym_second : sym_first;
    assign rb = cfg.swap ? sym_first  : sym_second;

    // Branch index g = {predecessor msb, input bit}.
    for (genvar g = 0; g < 4; g++) begin : g_branch
        localparam logic [0:0] PMSB = 1'(g / 2);
        localparam logic [0:0] BIT  = 1'(g % 2);
        logic [CONSTR-1:0] win;
        logic              ea, eb;
        assign win   = {PMSB, pair_idx, BIT};
        assign ea    = gen_parity(POLY_A, win) ^ cfg.inv_a;
        assign eb    = gen_parity(POLY_B, win) ^ cfg.inv_b;
        assign bm[g] = sym_cost(ra, ea) + sym_cost(rb, eb);
    end
endmodule

// File: rtl/sdv_acs.sv
module sdv_acs
    import sdv_pkg::*;
(
    input  logic [MW-1:0]  pm_lo,
    input  logic [MW-1:0]  pm_hi,
    input  logic [BMW-1:0] bm_lo,
    input  logic [BMW-1:0] bm_hi,
    output logic [MW-1:0]  metric,
    output logic           pick_hi
);
    logic [MW-1:0] cand_lo, cand_hi;
    assign cand_lo = pm_lo + MW'(bm_lo);
    assign cand_hi = pm_hi + MW'(bm_hi);
    // Equal candidates keep the predecessor whose top state bit is 0.
    assign pick_hi = cand_hi < cand_lo;
    assign metric  = pick_hi ? cand_hi : cand_lo;
endmodule

// File: rtl/sdv_decmem.sv
module sdv_decmem #(
    parameter int DEPTH = 70,
    parameter int AW    = 7,
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [1 << AW];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

    assert_dec_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/sdv_decoder.sv
module sdv_decoder
    import sdv_pkg::*;
#(
    parameter int              MAX_BITS  = 64,
    parameter logic [CONSTR-1:0] POLY_A  = 7'o171,
    parameter logic [CONSTR-1:0] POLY_B  = 7'o133,
    parameter logic [MW-1:0]   INIT_BIAS = 16'd4096,
    localparam int             LW        = $clog2(MAX_BITS + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           frame_start,
    input  logic [LW-1:0]  frame_bits,
    input  logic [STW-1:0] start_state,
    input  logic [STW-1:0] end_state,
    input  logic           inv_a,
    input  logic           inv_b,
    input  logic           swap_pair,
    input  logic           sym_valid,
    output logic           sym_ready,
    input  logic [SYMW-1:0] sym_first,
    input  logic [SYMW-1:0] sym_second,
    output logic           byte_valid,
    output logic [7:0]     byte_data,
    output logic           byte_last,
    output logic           busy,
    output logic           len_err
);
    localparam int TAIL      = STW;
    localparam int MAX_STEPS = MAX_BITS + TAIL;
    localparam int SCW       = $clog2(MAX_STEPS + 1);
    localparam int OBW       = 1 << SCW;
    localparam int NBYTES    = (MAX_BITS + 7) / 8;
    localparam int BCW       = $clog2(NBYTES + 1);

    phase_t              phase;
    cfg_t                cfg_q;
    logic [SCW-1:0]      nbits_q, total_q, step_q, tb_t;
    logic [BCW-1:0]      nbytes_q, bidx;
    logic [STW-1:0]      endst_q, tb_state;
    logic [STW-2:0]      pidx;
    logic [SYMW-1:0]     sa_q, sb_q;
    logic [MW-1:0]       pm [NSTATE];
    logic [MW-1:0]       pn [NSTATE];
    logic [MW-1:0]       runmin;
    logic [NSTATE-1:0]   decw, rd_word;
    logic [OBW-1:0]      obits;
    logic                len_bad, pm_top;

    logic [3:0][BMW-1:0] bm;
    logic [1:0][MW-1:0]  nm;
    logic [1:0]          pk;
    logic [MW-1:0]       pm_lo, pm_hi, pair_min;

    assign len_bad = (frame_bits == '0) || (int'(frame_bits) > MAX_BITS);

    assign pm_lo    = pm[{1'b0, pidx}];
    assign pm_hi    = pm[{1'b1, pidx}];
    assign pair_min = (nm[1] < nm[0]) ? nm[1] : nm[0];

    sdv_bmu #(.POLY_A(POLY_A), .POLY_B(POLY_B)) u_bmu (
        .pair_idx(pidx), .cfg(cfg_q), .sym_first(sa_q), .sym_second(sb_q), .bm(bm)
    );

    for (genvar b = 0; b < 2; b++) begin : g_acs
        sdv_acs u_acs (
            .pm_lo(pm_lo), .pm_hi(pm_hi), .bm_lo(bm[b]), .bm_hi(bm[2 + b]),
            .metric(nm[b]), .pick_hi(pk[b])
        );
    end

    sdv_decmem #(.DEPTH(MAX_STEPS), .AW(SCW), .WIDTH(NSTATE)) u_mem (
        .clk(clk), .rst(rst), .wr_en(phase == ST_COMMIT), .wr_addr(step_q),
        .wr_data(decw), .rd_addr(tb_t), .rd_data(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            cfg_q    <= '0;
            nbits_q  <= '0;
            total_q  <= '0;
            step_q   <= '0;
            tb_t     <= '0;
            nbytes_q <= '0;
            bidx     <= '0;
            endst_q  <= '0;
            tb_state <= '0;
            pidx     <= '0;
            sa_q     <= '0;
            sb_q     <= '0;
            runmin   <= '0;
            decw     <= '0;
            obits    <= '0;
            len_err  <= 1'b0;
            for (int i = 0; i < NSTATE; i++) begin
                pm[i] <= '0;
                pn[i] <= '0;
            end
        end else begin
            case (phase)
                ST_IDLE: if (frame_start) begin
                    if (len_bad) begin
                        len_err <= 1'b1;
                    end else begin
                        len_err  <= 1'b0;
                        cfg_q    <= '{inv_a: inv_a, inv_b: inv_b, swap: swap_pair};
                        nbits_q  <= SCW'(frame_bits);
                        total_q  <= SCW'(int'(frame_bits) + TAIL);
                        nbytes_q <= BCW'((int'(frame_bits) + 7) / 8);
                        endst_q  <= end_state;
                        step_q   <= '0;
                        obits    <= '0;
                        for (int i = 0; i < NSTATE; i++)
                            pm[i] <= (i == int'(start_state)) ? '0 : INIT_BIAS;
                        phase    <= ST_WAIT;
                    end
                end
                ST_WAIT: if (sym_valid) begin
                    sa_q  <= sym_first;
                    sb_q  <= sym_second;
                    pidx  <= '0;
                    phase <= ST_ACS;
                end
                ST_ACS: begin
                    pn[{pidx, 1'b0}]   <= nm[0];
                    pn[{pidx, 1'b1}]   <= nm[1];
                    decw[{pidx, 1'b0}] <= pk[0];
                    decw[{pidx, 1'b1}] <= pk[1];
                    if (pidx == '0 || pair_min < runmin) runmin <= pair_min;
                    pidx <= pidx + 1'b1;
                    if (int'(pidx) == NPAIR - 1) phase <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    for (int i = 0; i < NSTATE; i++) pm[i] <= pn[i] - runmin;
                    step_q <= step_q + 1'b1;
                    if (step_q == total_q - 1'b1) begin
                        tb_t     <= total_q - 1'b1;
                        tb_state <= endst_q;
                        phase    <= ST_TRACE;
                    end else begin
                        phase <= ST_WAIT;
                    end
                end
                ST_TRACE: begin
                    if (tb_t < nbits_q) obits[tb_t] <= tb_state[0];
                    tb_state <= {rd_word[tb_state], tb_state[STW-1:1]};
                    if (tb_t == '0) begin
                        bidx  <= '0;
                        phase <= ST_EMIT;
                    end else begin
                        tb_t <= tb_t - 1'b1;
                    end
                end
                ST_EMIT: begin
                    bidx <= bidx + 1'b1;
                    if (bidx == nbytes_q - 1'b1) phase <= ST_IDLE;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_data = '0;
        for (int k = 0; k < 8; k++)
            byte_data[7 - k] = obits[SCW'({bidx, 3'b000}) + SCW'(k)];
    end

    always_comb begin
        pm_top = 1'b0;
        for (int i = 0; i < NSTATE; i++) pm_top = pm_top | pm[i][MW-1];
    end

    assign sym_ready  = (phase == ST_WAIT);
    assign byte_valid = (phase == ST_EMIT);
    assign byte_last  = (phase == ST_EMIT) && (bidx == nbytes_q - 1'b1);
    assign busy       = (phase != ST_IDLE);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        !pm_top);
    assert_ready_excl_R1: assert property (@(posedge clk) disable iff (rst)
        sym_ready |-> !byte_valid);
    assert_step_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> !sym_ready);
    assert_len_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && frame_start && len_bad) |=> (len_err && !busy));
    assert_last_valid_R8: assert property (@(posedge clk) disable iff (rst)
        byte_last |-> byte_valid);
    assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(byte_last));
endmodule

// File: tb/sdv_decoder_test.sv
module sdv_decoder_test;
    import sdv_pkg::*;

    localparam int MAXB = 64;
    localparam int TAIL = 6;
    localparam int LW   = $clog2(MAXB + 2);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic [LW-1:0] frame_bits = '0;
    logic [5:0]    start_state = '0, end_state = '0;
    logic          inv_a = 1'b0, inv_b = 1'b0, swap_pair = 1'b0;
    logic          sym_valid = 1'b0;
    logic          sym_ready;
    logic [7:0]    sym_first = '0, sym_second = '0;
    logic          byte_valid, byte_last, busy, len_err;
    logic [7:0]    byte_data;

    sdv_decoder #(.MAX_BITS(MAXB)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_bits(frame_bits),
        .start_state(start_state), .end_state(end_state), .inv_a(inv_a),
        .inv_b(inv_b), .swap_pair(swap_pair), .sym_valid(sym_valid),
        .sym_ready(sym_ready), .sym_first(sym_first), .sym_second(sym_second),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .busy(busy), .len_err(len_err)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] rng = 32'h2545_f491;
    logic [MAXB-1:0] data_v;
    logic [7:0]  syms [2*(MAXB+TAIL)];
    logic [7:0]  got [16];

    function automatic logic [31:0] xs(input logic [31:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int nb, input logic [5:0] ss, input logic [5:0] es,
                             input bit ia, input bit ib, input bit sw, input bit noisy,
                             input string req);
        logic [5:0] s;
        logic [6:0] w;
        logic       b, ea, eb;
        logic [7:0] va, vb, expb;
        int         nsteps, ngot, last_pos, lat, nexp;
        nsteps = nb + TAIL;
        for (int i = 0; i < nb; i++) begin
            data_v[i] = rng[0];
            rng = xs(rng);
        end
        s = ss;
        for (int k = 0; k < nsteps; k++) begin
            b  = (k < nb) ? data_v[k] : es[5 - (k - nb)];
            w  = {s, b};
            ea = (^(w & 7'o171)) ^ ia;
            eb = (^(w & 7'o133)) ^ ib;
            va = ea ? 8'd255 : 8'd0;
            vb = eb ? 8'd255 : 8'd0;
            syms[2*k]     = sw ? vb : va;
            syms[2*k + 1] = sw ? va : vb;
            s = {s[4:0], b};
        end
        if (noisy) begin
            for (int m = 0; m < 2*nsteps; m++) begin
                if (m % 23 == 7)      syms[m] = 8'd255 - syms[m];
                else if (m % 31 == 3) syms[m] = 8'd128;
                else if (m % 7 == 2)  syms[m] = (syms[m] != 0) ? 8'd190 : 8'd70;
            end
        end
        @(negedge clk);
        frame_bits = LW'(nb); start_state = ss; end_state = es;
        inv_a = ia; inv_b = ib; swap_pair = sw; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(busy == 1'b1, {req, " R11 busy after start"}, int'(busy), 1);
        check(len_err == 1'b0, "R9 len_err cleared by good start", int'(len_err), 0);
        for (int k = 0; k < nsteps; k++) begin
            sym_valid = 1'b1;
            sym_first = syms[2*k];
            sym_second = syms[2*k + 1];
            if (k == 2) begin
                frame_start = 1'b1;
                frame_bits = '0;
            end
            while (!sym_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            sym_valid = 1'b0;
            frame_start = 1'b0;
            if (k == 0) begin
                lat = 1;
                while (!sym_ready) begin
                    @(negedge clk);
                    lat++;
                end
                check(lat == NPAIR + 2, "R10 step latency (negedges incl. accept)", lat, NPAIR + 2);
            end
        end
        ngot = 0;
        last_pos = -1;
        while (busy) begin
            if (byte_valid && ngot < 16) begin
                got[ngot] = byte_data;
                if (byte_last) last_pos = ngot;
                ngot++;
            end
            @(negedge clk);
        end
        nexp = (nb + 7) / 8;
        check(ngot == nexp, "R8 byte count", ngot, nexp);
        check(last_pos == nexp - 1, "R8 byte_last position", last_pos, nexp - 1);
        check(len_err == 1'b0, "R11 start ignored while busy", int'(len_err), 0);
        for (int k = 0; k < nexp && k < ngot; k++) begin
            expb = '0;
            for (int j = 0; j < 8; j++)
                if (8*k + j < nb) expb[7 - j] = data_v[8*k + j];
            check(got[k] == expb, {req, " R8 decoded byte"}, int'(got[k]), int'(expb));
        end
    endtask

    task automatic reject(input int nb);
        @(negedge clk);
        frame_bits = LW'(nb);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(len_err == 1'b1, "R9 len_err on bad length", int'(len_err), 1);
        check(busy == 1'b0, "R9 stays idle on bad length", int'(busy), 0);
        sym_valid = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (sym_ready || byte_valid || busy) begin
                check(1'b0, "R9 symbols ignored after reject", 1, 0);
                break;
            end
        end
        sym_valid = 1'b0;
        check(len_err == 1'b1, "R9 len_err holds", int'(len_err), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11 reset busy", int'(busy), 0);
        check(sym_ready == 1'b0, "R1 reset sym_ready", int'(sym_ready), 0);
        check(byte_valid == 1'b0, "R8 reset byte_valid", int'(byte_valid), 0);
        check(len_err == 1'b0, "R9 reset len_err", int'(len_err), 0);

        run_frame(16, 6'h00, 6'h00, 0, 0, 0, 0, "R2");
        for (int c = 0; c < 8; c++)
            run_frame(20, 6'h00, 6'h00, c[0], c[1], c[2], 0, c[2] ? "R7" : "R6");
        run_frame(24, 6'h2B, 6'h15, 0, 0, 0, 0, "R3,R4");
        run_frame(17, 6'h3F, 6'h01, 1, 0, 0, 0, "R3,R4");
        run_frame(12, 6'h01, 6'h3E, 0, 1, 1, 0, "R3,R4");
        run_frame(40, 6'h11, 6'h22, 1, 0, 1, 1, "R1,R5");
        run_frame(MAXB, 6'h00, 6'h00, 0, 0, 0, 1, "R5,R9 max length");
        run_frame(13, 6'h05, 6'h00, 0, 1, 0, 0, "R8 partial");
        run_frame(1, 6'h00, 6'h07, 0, 0, 1, 0, "R8 single bit");
        reject(0);
        reject(MAXB + 1);
        run_frame(9, 6'h00, 6'h00, 1, 1, 0, 0, "R9 after reject");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule